// File: doc/BRIEF.md
# Stacked-Carrier Gate Pattern Modulator for Cascaded Five-Level Cells

This block drives one phase leg built from a chain of identical five-level cells. Each cell is an H-bridge with one extra bidirectional switch that ties its first leg to the capacitor midpoint. A signed reference sample arrives each clock. The block compares the sample against a stack of equal-period triangular carriers. The carriers are all in phase and are stacked in amplitude, each in a band of its own. The number of carriers that the reference exceeds sets a signed phase level.

That phase level is split across the cells. The first cell fills up before the next one takes any share. Each cell's share is then turned into one legal five-switch gate pattern. A cell at zero has two equivalent patterns, and the block alternates between them once per carrier period so that the switch stress is shared.

The cell gate vector and the phase level are both registered, so nothing downstream sees a glitch. The reference normally comes from a sine table or from a register.

Top module: `mlpd_gate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `lvl_o` = 0 and every cell showing the zero pattern with (S1,S2,S3,S4,S5) = (0,0,1,0,1). The carrier restarts at value 0 and rises, and the zero-pattern selector returns to that same first pattern.
- R2: Carrier: the carrier value is 0 after reset and moves by one each clock. It rises to `PER` and then falls back to 0, so one period lasts 2·`PER` clocks. All 4·`NCELL` carriers share this value. Carrier k is that value plus k·`PER`.
- R3: The reference is shifted up by 2·`NCELL`·`PER`. The level is the count of carriers strictly below the shifted reference, minus 2·`NCELL`. It is computed from the reference and the carrier value in effect before the clock edge, and it appears on `lvl_o` after that one edge. It saturates at ±2·`NCELL`.
- R4: The phase level is split into cell levels in half-Vdc steps, each between −2 and +2. Cells fill in order starting from cell 0. A later cell is non-zero only if every earlier cell is at ±2 with the same sign. The cell levels sum to `lvl_o`.
- R5: Cell i occupies `gates_o[5i+4:5i]` as {S5,S4,S3,S2,S1}, with S1 in the lowest bit. The encodings are:
  - +2 → (S1..S5) 0,1,0,0,1
  - +1 → 1,0,0,0,1
  - −1 → 1,0,0,1,0
  - −2 → 0,0,1,1,0
- R6: A cell at level 0 shows pattern A, (0,0,1,0,1), while the zero selector is 0, and pattern B, (0,1,0,1,0), while it is 1. The selector flips on the clock edge at which the falling carrier goes from 1 to 0.
- R7: Every emitted cell pattern is one of the six listed in R5 and R6. Its value (S5−S4)·(S1 + 2·|S2−S4|·|S3−S5|), in half steps, equals the cell level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | RW | Signed reference sample |
| gates_o | output | 5·NCELL | Registered gate patterns, 5 bits per cell |
| lvl_o | output | LW | Registered signed phase level |

## Verification
The hardest case to reach from the ports is the alternation of the zero pattern. It only shows on a cell that sits at zero across the edge where the falling carrier reaches 0, and that edge comes once every 2·`PER` clocks. The bench holds references near mid-scale for several full carrier periods, so that the upper cells stay at zero through those edges. It predicts the carrier value and the selector from the reset edge, so every cycle's pattern is known. A mid-run reset then checks that both the selector and the carrier phase restart.

// File: rtl/mlpd_pkg.sv
package mlpd_pkg;

    // cell level in half-Vdc steps, -2..+2
    typedef logic signed [2:0] clvl_t;

    // packed so that s1 lands in the least significant bit
    typedef struct packed {
        logic s5;
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } pat_t;

    localparam pat_t PAT_ZA = 5'b10100;
    localparam pat_t PAT_ZB = 5'b01010;
    localparam pat_t PAT_P2 = 5'b10010;
    localparam pat_t PAT_P1 = 5'b10001;
    localparam pat_t PAT_N1 = 5'b01001;
    localparam pat_t PAT_N2 = 5'b01100;

    function automatic pat_t enc_cell(clvl_t l, logic zsel);
        pat_t p;
        case (l)
            3'sd2:   p = PAT_P2;
            3'sd1:   p = PAT_P1;
            -3'sd1:  p = PAT_N1;
            -3'sd2:  p = PAT_N2;
            default: p = zsel ? PAT_ZB : PAT_ZA;
        endcase
        return p;
    endfunction

    // cell output in half steps from the switch states
    function automatic int pat_value(pat_t p);
        int d;
        int a;
        int b;
        d = int'(p.s5) - int'(p.s4);
        a = (p.s2 != p.s4) ? 1 : 0;
        b = (p.s3 != p.s5) ? 1 : 0;
        return d * (int'(p.s1) + 2 * a * b);
    endfunction

    function automatic logic pat_legal(pat_t p);
        return (p == PAT_ZA) || (p == PAT_ZB) || (p == PAT_P2) ||
               (p == PAT_P1) || (p == PAT_N1) || (p == PAT_N2);
    endfunction

endpackage

// File: rtl/mlpd_carrier.sv
module mlpd_carrier #(
    parameter int PER = 8,
    localparam int CW = $clog2(PER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] carr,
    output logic          zsel
);
    logic rising;

    always_ff @(posedge clk) begin
        if (rst) begin
            carr   <= '0;
            rising <= 1'b1;
            zsel   <= 1'b0;
        end else if (rising) begin
            if (carr == CW'(PER)) begin
                carr   <= CW'(PER - 1);
                rising <= 1'b0;
            end else begin
                carr <= carr + 1'b1;
            end
        end else begin
            if (carr == CW'(1)) begin
                carr   <= '0;
                rising <= 1'b1;
                zsel   <= ~zsel;
            end else begin
                carr <= carr - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mlpd_compare.sv
module mlpd_compare #(
    parameter int NCELL = 2,
    parameter int PER   = 8,
    parameter int RW    = 8,
    localparam int CW   = $clog2(PER + 1),
    localparam int NCAR = 4 * NCELL,
    localparam int LW   = $clog2(2 * NCELL + 1) + 1,
    localparam int AW   = ((RW > $clog2(NCAR * PER + 1)) ? RW : $clog2(NCAR * PER + 1)) + 3
) (
    input  logic signed [RW-1:0] ref_in,
    input  logic        [CW-1:0] carr,
    output logic signed [LW-1:0] lvl
);
    logic signed [AW-1:0] ref_u;

    always_comb begin
        int cnt;
        ref_u = AW'(ref_in) + AW'(2 * NCELL * PER);
        cnt   = 0;
        for (int k = 0; k < NCAR; k++) begin
            if (ref_u > $signed(AW'(k * PER) + AW'(carr))) cnt++;
        end
        lvl = LW'(cnt - 2 * NCELL);
    end
endmodule

// File: rtl/mlpd_split.sv
module mlpd_split
    import mlpd_pkg::*;
#(
    parameter int NCELL = 2,
    localparam int LW   = $clog2(2 * NCELL + 1) + 1
) (
    input  logic signed [LW-1:0] lvl,
    output clvl_t                cell_lvl [NCELL]
);
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        always_comb begin
            int mag;
            int m;
            mag = (lvl < 0) ? -int'(lvl) : int'(lvl);
            m   = mag - 2 * i;
            if (m < 0) m = 0;
            if (m > 2) m = 2;
            cell_lvl[i] = clvl_t'((lvl < 0) ? -m : m);
        end
    end
endmodule

// File: rtl/mlpd_gate_gen.sv
module mlpd_gate_gen
    import mlpd_pkg::*;
#(
    parameter int NCELL = 2,
    parameter int PER   = 8,
    parameter int RW    = 8,
    localparam int CW   = $clog2(PER + 1),
    localparam int LW   = $clog2(2 * NCELL + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [RW-1:0] ref_in,
    output logic [5*NCELL-1:0]   gates_o,
    output logic signed [LW-1:0] lvl_o
);
    logic [CW-1:0]        carr;
    logic                 zsel;
    logic signed [LW-1:0] lvl_d;
    clvl_t                cell_lvl [NCELL];

    mlpd_carrier #(.PER(PER)) u_carr (
        .clk  (clk),
        .rst  (rst),
        .carr (carr),
        .zsel (zsel)
    );

    mlpd_compare #(.NCELL(NCELL), .PER(PER), .RW(RW)) u_cmp (
        .ref_in (ref_in),
        .carr   (carr),
        .lvl    (lvl_d)
    );

    mlpd_split #(.NCELL(NCELL)) u_split (
        .lvl      (lvl_d),
        .cell_lvl (cell_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_o <= '0;
        else     lvl_o <= lvl_d;
    end

    for (genvar i = 0; i < NCELL; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) gates_o[5*i +: 5] <= PAT_ZA;
            else     gates_o[5*i +: 5] <= enc_cell(cell_lvl[i], zsel);
        end
    end
endmodule

// File: rtl/mlpd_chk.sv
module mlpd_chk
    import mlpd_pkg::*;
#(
    parameter int NCELL = 2,
    localparam int LW   = $clog2(2 * NCELL + 1) + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [5*NCELL-1:0]   gates_o,
    input logic signed [LW-1:0] lvl_o
);
    int vals [NCELL];
    int vsum;

    always_comb begin
        vsum = 0;
        for (int i = 0; i < NCELL; i++) begin
            vals[i] = pat_value(pat_t'(gates_o[5*i +: 5]));
            vsum    = vsum + vals[i];
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lvl_o == '0 && gates_o == {NCELL{PAT_ZA}}));

    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(lvl_o) <= 2 * NCELL) && (int'(lvl_o) >= -2 * NCELL));

    // R4
    cell_sum_chk: assert property (@(posedge clk) disable iff (rst)
        vsum == int'(lvl_o));

    for (genvar i = 0; i < NCELL; i++) begin : g_c
        // R7
        legal_pat_chk: assert property (@(posedge clk) disable iff (rst)
            pat_legal(pat_t'(gates_o[5*i +: 5])));
        if (i > 0) begin : g_fill
            // R4
            fill_order_chk: assert property (@(posedge clk) disable iff (rst)
                (vals[i] != 0) |-> (vals[i-1] == ((vals[i] > 0) ? 2 : -2)));
        end
    end
endmodule

bind mlpd_gate_gen mlpd_chk #(.NCELL(NCELL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .gates_o (gates_o),
    .lvl_o   (lvl_o)
);

// File: tb/mlpd_gate_gen_bench.sv
`timescale 1ns/1ps
module mlpd_gate_gen_bench;
    localparam int NCELL = 2;
    localparam int PER   = 8;
    localparam int RW    = 8;
    localparam int LW    = $clog2(2 * NCELL + 1) + 1;
    localparam int NV    = 10;
    localparam int HOLD  = 3 * 2 * PER;
    // reference samples walked by the main loop; expected outputs follow R2..R6
    localparam int VEC [NV] = '{0, 5, -5, 12, -12, 20, -27, 31, 100, -100};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [RW-1:0] ref_in = '0;
    logic [5*NCELL-1:0]   gates_o;
    logic signed [LW-1:0] lvl_o;

    int total = 0;
    int bad = 0;
    int mc, mup, mz;

    always #2.5 clk = ~clk;

    mlpd_gate_gen #(.NCELL(NCELL), .PER(PER), .RW(RW)) u_mlpd_gate_gen (
        .clk(clk), .rst(rst), .ref_in(ref_in), .gates_o(gates_o), .lvl_o(lvl_o)
    );

    function automatic int m_lvl(int r, int c);
        int cnt = 0;
        for (int k = 0; k < 4 * NCELL; k++)
            if (r + 2 * NCELL * PER > k * PER + c) cnt++;
        return cnt - 2 * NCELL;
    endfunction

    function automatic logic [4:0] m_pat(int l, int z);
        case (l)
            2:  return 5'b10010;
            1:  return 5'b10001;
            -1: return 5'b01001;
            -2: return 5'b01100;
            default: return (z != 0) ? 5'b01010 : 5'b10100;
        endcase
    endfunction

    function automatic logic [5*NCELL-1:0] m_gates(int l, int z);
        logic [5*NCELL-1:0] g;
        for (int i = 0; i < NCELL; i++) begin
            int mag = (l < 0) ? -l : l;
            int m = mag - 2 * i;
            if (m < 0) m = 0;
            if (m > 2) m = 2;
            g[5*i +: 5] = m_pat((l < 0) ? -m : m, z);
        end
        return g;
    endfunction

    task automatic model_reset();
        mc = 0; mup = 1; mz = 0;
    endtask

    task automatic model_step();
        if (mup != 0) begin
            if (mc == PER) begin mc = PER - 1; mup = 0; end
            else mc++;
        end else begin
            if (mc == 1) begin mc = 0; mup = 1; mz = 1 - mz; end
            else mc--;
        end
    endtask

    task automatic check(string req, logic [5*NCELL-1:0] eg, int el);
        total++;
        if (gates_o !== eg || int'(lvl_o) != el) begin
            bad++;
            $display("FAIL %s: gates=%b lvl=%0d expected gates=%b lvl=%0d",
                     req, gates_o, lvl_o, eg, el);
        end
    endtask

    // drive one sample at a falling edge, check the result one edge later (R3 latency)
    task automatic step(int r, string req);
        int el;
        logic [5*NCELL-1:0] eg;
        ref_in = RW'(r);
        el = m_lvl(r, mc);
        eg = m_gates(el, mz);
        model_step();
        @(negedge clk);
        check(req, eg, el);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ref_in = 8'sd50;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {NCELL{5'b10100}}, 0);
        rst = 1'b0;
        model_reset();

        // R2 R3 R4 R5 R6 table walk, each held for several carrier periods
        for (int v = 0; v < NV; v++)
            for (int n = 0; n < HOLD; n++)
                step(VEC[v], "R3/R4/R5");

        // R6 zero toggling: mid-scale keeps the upper cell at zero across bottom turns
        for (int n = 0; n < 4 * PER; n++) step(1, "R6");

        // R3 saturation corners
        for (int n = 0; n < 2 * PER; n++) step(127, "R3");
        for (int n = 0; n < 2 * PER; n++) step(-128, "R3");

        // R2 carrier phase dependence: exact band edge
        for (int n = 0; n < 2 * PER; n++) step(PER, "R2");

        // R1 mid-run reset restarts carrier and zero selector
        for (int n = 0; n < 5; n++) step(3, "R2");
        rst = 1'b1;
        @(negedge clk);
        check("R1", {NCELL{5'b10100}}, 0);
        rst = 1'b0;
        model_reset();
        for (int n = 0; n < 4 * PER; n++) step(-2, "R1/R6");

        // R7 sweep through every level
        for (int r = -40; r <= 40; r += 3) step(r, "R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule